// File: doc/BRIEF.md
# Interprocessor interrupt command unit

This block is the send side of a local interrupt controller, as seen by software. Software reaches it through a plain 32-bit register bus. Each access is a write strobe with an address and write data. Read data is combinational on the address.

The register set has four parts:
- an 8-bit processor identity register;
- a register holding the controller enable and the spurious vector;
- a write-only end-of-interrupt register, which produces a one-cycle pulse;
- a 64-bit command register, split into an upper word that holds the destination and a lower word that holds everything else.

A write to the lower command word launches one interprocessor message on a valid/ready output port. The message carries the vector, delivery mode, destination mode, level, trigger mode, destination shorthand and destination. A delivery-status bit in the lower word reads pending from the launch until the port accepts the message. Software polls that bit before it issues the next command.

A command written while a message is still outstanding is dropped, and a sticky flag records the drop. While the controller is disabled, commands are stored but nothing is sent. The message payload is captured at launch and held until the handshake. Later bus writes therefore cannot disturb a message in flight.

Top module: `ipi_cmd_unit`

## Requirements
- R1: After reset, every readable register reads zero, msg_valid_o is 0, cmd_drop_o is 0 and eoi_o is 0.
- R2: Offset 0x020 stores write-data bits 31:24 as the processor ID and reads them back in bits 31:24. All other bits of that register read 0.
- R3: Offset 0x0F0 stores bits 7:0 as the spurious vector and bit 8 as the enable (1 = enabled). Both read back in those positions, and bits 31:9 read 0.
- R4: Any write to offset 0x0B0 makes eoi_o high for exactly the one cycle after the write edge. Reading 0x0B0 returns 0.
- R5: Offset 0x310 stores the destination in bits 31:24 and reads it back there, with all other bits 0. Writing it launches nothing.
- R6: A write to offset 0x300 while enabled and idle raises msg_valid_o in the cycle after the write edge. The message fields come from the write data, and the destination is the stored value of 0x310 at that moment. The lower-word layout is:
  - vector in bits 7:0;
  - delivery mode in bits 10:8;
  - destination mode in bit 11 (1 = logical);
  - level in bit 14;
  - trigger mode in bit 15;
  - shorthand in bits 19:18.
- R7: Bit 12 of offset 0x300 reads 1 while a message is pending. It and msg_valid_o return to 0 in the cycle after the edge where msg_valid_o and msg_ready_i are both 1.
- R8: While a message is pending and not accepted, msg_valid_o stays 1 and every message field stays unchanged, even if offset 0x310 is rewritten.
- R9: A write to offset 0x300 while a message is pending has no effect: the stored fields do not change and no second message follows. It also sets cmd_drop_o, which stays 1 until reset and reads back in bit 13 of offset 0x300.
- R10: While the enable bit is 0, a write to offset 0x300 stores its fields for readback but launches no message, and bit 12 stays 0.
- R11: The message port carries every delivery mode code (000 through 111, reserved ones included) and every shorthand code (00 destination field, 01 self, 10 all including self, 11 all excluding self) unchanged from the write data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Write strobe, sampled at the rising edge |
| bus_addr | input | ADDR_W | Register offset for the write and for read data |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data for bus_addr (combinational) |
| eoi_o | output | 1 | One-cycle end-of-interrupt pulse |
| msg_valid_o | output | 1 | Message valid (the pending status) |
| msg_ready_i | input | 1 | Message accepted by the fabric |
| msg_vector_o | output | 8 | Message vector |
| msg_dmode_o | output | 3 | Delivery mode code |
| msg_dlogical_o | output | 1 | Destination mode, 1 = logical |
| msg_level_o | output | 1 | Level bit |
| msg_trig_o | output | 1 | Trigger mode, 1 = level |
| msg_short_o | output | 2 | Destination shorthand code |
| msg_dest_o | output | 8 | Destination captured at launch |
| cmd_drop_o | output | 1 | Sticky flag for a command dropped while pending |

## Verification
The bench rewrites the destination word while a message waits for acceptance, which catches a design that drives the port from the live register rather than from a launch-time copy. It issues a second command while the first is pending. A design that accepted it would corrupt the readback fields, and one that forgot the flag would leave cmd_drop_o low. It sends a command while disabled, which catches a design that launches regardless of the enable. It samples status on both sides of the handshake edge, and a design that cleared early or late would show bit 12 at the wrong time. Every delivery mode and shorthand code is also sent, so a mis-sliced field shows up as a wrong port value.

// File: rtl/ipi_cmd_pkg.sv
package ipi_cmd_pkg;

   localparam int IPI_VEC_W   = 8;
   localparam int IPI_DEST_W  = 8;
   localparam int IPI_DMODE_W = 3;
   localparam int IPI_SHORT_W = 2;

   // Fields of the lower command word, kept for readback and for sending
   typedef struct packed {
      logic [IPI_SHORT_W-1:0] shorthand;
      logic                   trig;
      logic                   level;
      logic                   dlogical;
      logic [IPI_DMODE_W-1:0] dmode;
      logic [IPI_VEC_W-1:0]   vector;
   } ipi_cmd_t;

   // Bit positions of the lower command word, decoded by software
   localparam int LO_VEC_LSB   = 0;
   localparam int LO_DMODE_LSB = 8;
   localparam int LO_DLOG_BIT  = 11;
   localparam int LO_STAT_BIT  = 12;
   localparam int LO_DROP_BIT  = 13;
   localparam int LO_LEVEL_BIT = 14;
   localparam int LO_TRIG_BIT  = 15;
   localparam int LO_SHORT_LSB = 18;

endpackage

// File: rtl/ipi_cfg_regs.sv
module ipi_cfg_regs
   import ipi_cmd_pkg::*;
#(
   parameter int DATA_W        = 32,
   parameter int ID_LSB        = 24,
   parameter int DEST_LSB      = 24,
   parameter bit SPUR_LOW_ONES = 1'b0
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  wr,
   input  logic                  hit_id,
   input  logic                  hit_spur,
   input  logic                  hit_eoi,
   input  logic                  hit_dest,
   input  logic [DATA_W-1:0]     wdata,
   output logic [IPI_DEST_W-1:0] id_q,
   output logic [IPI_VEC_W-1:0]  spur_q,
   output logic                  en_q,
   output logic [IPI_DEST_W-1:0] dest_q,
   output logic                  eoi_q
);

   localparam int EN_BIT = IPI_VEC_W;

   logic [IPI_VEC_W-1:0] spur_d;

   generate
      if (SPUR_LOW_ONES) begin : g_spur_fixed
         // low nibble of the spurious vector is hardwired to ones
         assign spur_d = {wdata[IPI_VEC_W-1:4], 4'hF};
      end else begin : g_spur_free
         assign spur_d = wdata[IPI_VEC_W-1:0];
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         id_q   <= '0;
         spur_q <= SPUR_LOW_ONES ? IPI_VEC_W'(4'hF) : '0;
         en_q   <= 1'b0;
         dest_q <= '0;
         eoi_q  <= 1'b0;
      end else begin
         eoi_q <= wr && hit_eoi;
         if (wr && hit_id)
            id_q <= wdata[ID_LSB +: IPI_DEST_W];
         if (wr && hit_spur) begin
            spur_q <= spur_d;
            en_q   <= wdata[EN_BIT];
         end
         if (wr && hit_dest)
            dest_q <= wdata[DEST_LSB +: IPI_DEST_W];
      end
   end

   // R4: a pulse only follows an end-of-interrupt write
   assert_eoi_cause_R4: assert property (@(posedge clk) disable iff (!rst_n)
      eoi_q |-> $past(wr && hit_eoi));

   // R5: the destination only changes through its own register
   assert_dest_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr && hit_dest) |=> $stable(dest_q));

endmodule

// File: rtl/ipi_cmd_launch.sv
module ipi_cmd_launch
   import ipi_cmd_pkg::*;
#(
   parameter int DATA_W = 32
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  wr_lo,
   input  logic [DATA_W-1:0]     wdata,
   input  logic                  en,
   input  logic [IPI_DEST_W-1:0] dest_live,
   input  logic                  ready,
   output ipi_cmd_t              cmd_q,
   output logic [IPI_DEST_W-1:0] msg_dest_q,
   output logic                  pend_q,
   output logic                  drop_q
);

   ipi_cmd_t cmd_d;
   logic     accept;
   logic     launch;

   always_comb begin
      cmd_d.vector    = wdata[LO_VEC_LSB +: IPI_VEC_W];
      cmd_d.dmode     = wdata[LO_DMODE_LSB +: IPI_DMODE_W];
      cmd_d.dlogical  = wdata[LO_DLOG_BIT];
      cmd_d.level     = wdata[LO_LEVEL_BIT];
      cmd_d.trig      = wdata[LO_TRIG_BIT];
      cmd_d.shorthand = wdata[LO_SHORT_LSB +: IPI_SHORT_W];
   end

   assign accept = wr_lo && !pend_q;
   assign launch = accept && en;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cmd_q      <= '0;
         msg_dest_q <= '0;
         pend_q     <= 1'b0;
         drop_q     <= 1'b0;
      end else begin
         if (accept)
            cmd_q <= cmd_d;
         if (launch) begin
            pend_q     <= 1'b1;
            msg_dest_q <= dest_live;
         end else if (pend_q && ready) begin
            pend_q <= 1'b0;
         end
         if (wr_lo && pend_q)
            drop_q <= 1'b1;
      end
   end

   assert_launch_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_lo && !pend_q && en) |=> pend_q);

   assert_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (pend_q && ready) |=> !pend_q);

   assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (pend_q && !ready) |=> (pend_q && $stable(msg_dest_q) && $stable(cmd_q)));

   assert_drop_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_lo && pend_q) |=> (drop_q && $stable(cmd_q)));

   assert_drop_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
      drop_q |=> drop_q);

   assert_disabled_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (!en && !pend_q) |=> !pend_q);

endmodule

// File: rtl/ipi_read_mux.sv
module ipi_read_mux
   import ipi_cmd_pkg::*;
#(
   parameter int DATA_W   = 32,
   parameter int ID_LSB   = 24,
   parameter int DEST_LSB = 24,
   parameter int N_SRC    = 5
) (
   input  logic [N_SRC-1:0]      sel,
   input  logic [IPI_DEST_W-1:0] id_q,
   input  logic [IPI_VEC_W-1:0]  spur_q,
   input  logic                  en_q,
   input  logic [IPI_DEST_W-1:0] dest_q,
   input  ipi_cmd_t              cmd_q,
   input  logic                  pend_q,
   input  logic                  drop_q,
   output logic [DATA_W-1:0]     rdata
);

   logic [DATA_W-1:0] words [N_SRC];

   always_comb begin
      for (int k = 0; k < N_SRC; k++) words[k] = '0;
      words[0][ID_LSB +: IPI_DEST_W]         = id_q;
      words[1][IPI_VEC_W-1:0]                = spur_q;
      words[1][IPI_VEC_W]                    = en_q;
      // words[2] is the end-of-interrupt register and always reads zero
      words[3][LO_VEC_LSB +: IPI_VEC_W]      = cmd_q.vector;
      words[3][LO_DMODE_LSB +: IPI_DMODE_W]  = cmd_q.dmode;
      words[3][LO_DLOG_BIT]                  = cmd_q.dlogical;
      words[3][LO_STAT_BIT]                  = pend_q;
      words[3][LO_DROP_BIT]                  = drop_q;
      words[3][LO_LEVEL_BIT]                 = cmd_q.level;
      words[3][LO_TRIG_BIT]                  = cmd_q.trig;
      words[3][LO_SHORT_LSB +: IPI_SHORT_W]  = cmd_q.shorthand;
      words[4][DEST_LSB +: IPI_DEST_W]       = dest_q;
   end

   logic [DATA_W-1:0] masked [N_SRC];

   generate
      for (genvar g = 0; g < N_SRC; g++) begin : g_mask
         assign masked[g] = sel[g] ? words[g] : '0;
      end
   endgenerate

   always_comb begin
      rdata = '0;
      for (int k = 0; k < N_SRC; k++) rdata = rdata | masked[k];
   end

   always_comb begin
      assert_sel_onehot_R2: assert ($onehot0(sel));
   end

endmodule

// File: rtl/ipi_cmd_unit.sv
module ipi_cmd_unit
   import ipi_cmd_pkg::*;
#(
   parameter int          DATA_W        = 32,
   parameter int          ADDR_W        = 12,
   parameter logic [11:0] OFS_ID        = 12'h020,
   parameter logic [11:0] OFS_EOI       = 12'h0B0,
   parameter logic [11:0] OFS_SPUR      = 12'h0F0,
   parameter logic [11:0] OFS_CMD_LO    = 12'h300,
   parameter logic [11:0] OFS_CMD_HI    = 12'h310,
   parameter bit          SPUR_LOW_ONES = 1'b0
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   bus_wr,
   input  logic [ADDR_W-1:0]      bus_addr,
   input  logic [DATA_W-1:0]      bus_wdata,
   output logic [DATA_W-1:0]      bus_rdata,
   output logic                   eoi_o,
   output logic                   msg_valid_o,
   input  logic                   msg_ready_i,
   output logic [IPI_VEC_W-1:0]   msg_vector_o,
   output logic [IPI_DMODE_W-1:0] msg_dmode_o,
   output logic                   msg_dlogical_o,
   output logic                   msg_level_o,
   output logic                   msg_trig_o,
   output logic [IPI_SHORT_W-1:0] msg_short_o,
   output logic [IPI_DEST_W-1:0]  msg_dest_o,
   output logic                   cmd_drop_o
);

   localparam int N_SRC    = 5;
   localparam int FIELD_LSB = DATA_W - IPI_DEST_W;

   generate
      if (DATA_W != 32) begin : g_bad_data_w
         $error("ipi_cmd_unit: DATA_W must be 32");
      end
      if (ADDR_W < 12) begin : g_bad_addr_w
         $error("ipi_cmd_unit: ADDR_W must cover the offsets");
      end
   endgenerate

   logic hit_id, hit_spur, hit_eoi, hit_lo, hit_hi;

   assign hit_id   = (bus_addr == ADDR_W'(OFS_ID));
   assign hit_spur = (bus_addr == ADDR_W'(OFS_SPUR));
   assign hit_eoi  = (bus_addr == ADDR_W'(OFS_EOI));
   assign hit_lo   = (bus_addr == ADDR_W'(OFS_CMD_LO));
   assign hit_hi   = (bus_addr == ADDR_W'(OFS_CMD_HI));

   logic [IPI_DEST_W-1:0] id_q, dest_q, msg_dest_q;
   logic [IPI_VEC_W-1:0]  spur_q;
   logic                  en_q, pend_q, drop_q;
   ipi_cmd_t              cmd_q;

   ipi_cfg_regs #(
      .DATA_W        (DATA_W),
      .ID_LSB        (FIELD_LSB),
      .DEST_LSB      (FIELD_LSB),
      .SPUR_LOW_ONES (SPUR_LOW_ONES)
   ) u_cfg (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr       (bus_wr),
      .hit_id   (hit_id),
      .hit_spur (hit_spur),
      .hit_eoi  (hit_eoi),
      .hit_dest (hit_hi),
      .wdata    (bus_wdata),
      .id_q     (id_q),
      .spur_q   (spur_q),
      .en_q     (en_q),
      .dest_q   (dest_q),
      .eoi_q    (eoi_o)
   );

   ipi_cmd_launch #(
      .DATA_W (DATA_W)
   ) u_launch (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr_lo      (bus_wr && hit_lo),
      .wdata      (bus_wdata),
      .en         (en_q),
      .dest_live  (dest_q),
      .ready      (msg_ready_i),
      .cmd_q      (cmd_q),
      .msg_dest_q (msg_dest_q),
      .pend_q     (pend_q),
      .drop_q     (drop_q)
   );

   ipi_read_mux #(
      .DATA_W   (DATA_W),
      .ID_LSB   (FIELD_LSB),
      .DEST_LSB (FIELD_LSB),
      .N_SRC    (N_SRC)
   ) u_rd (
      .sel    ({hit_hi, hit_lo, hit_eoi, hit_spur, hit_id}),
      .id_q   (id_q),
      .spur_q (spur_q),
      .en_q   (en_q),
      .dest_q (dest_q),
      .cmd_q  (cmd_q),
      .pend_q (pend_q),
      .drop_q (drop_q),
      .rdata  (bus_rdata)
   );

   assign msg_valid_o    = pend_q;
   assign msg_vector_o   = cmd_q.vector;
   assign msg_dmode_o    = cmd_q.dmode;
   assign msg_dlogical_o = cmd_q.dlogical;
   assign msg_level_o    = cmd_q.level;
   assign msg_trig_o     = cmd_q.trig;
   assign msg_short_o    = cmd_q.shorthand;
   assign msg_dest_o     = msg_dest_q;
   assign cmd_drop_o     = drop_q;

   // R5: writing the upper word alone never starts a message
   assert_hi_no_launch_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (!msg_valid_o && !(bus_wr && hit_lo)) |=> !msg_valid_o);

endmodule

// File: tb/ipi_cmd_unit_test.sv
module ipi_cmd_unit_test;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_wr = 1'b0;
   logic [11:0] bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        eoi_o, msg_valid_o, msg_ready_i;
   logic [7:0]  msg_vector_o, msg_dest_o;
   logic [2:0]  msg_dmode_o;
   logic        msg_dlogical_o, msg_level_o, msg_trig_o, cmd_drop_o;
   logic [1:0]  msg_short_o;

   int checks = 0;
   int errors = 0;
   bit done   = 0;
   bit drop_exp = 0;

   initial msg_ready_i = 1'b0;
   always #2 clk = ~clk;

   ipi_cmd_unit uut (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .eoi_o(eoi_o),
      .msg_valid_o(msg_valid_o), .msg_ready_i(msg_ready_i),
      .msg_vector_o(msg_vector_o), .msg_dmode_o(msg_dmode_o),
      .msg_dlogical_o(msg_dlogical_o), .msg_level_o(msg_level_o),
      .msg_trig_o(msg_trig_o), .msg_short_o(msg_short_o),
      .msg_dest_o(msg_dest_o), .cmd_drop_o(cmd_drop_o)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   function automatic logic [31:0] lo_word(input logic [7:0] v, input logic [2:0] dm,
                                           input logic lg, input logic lv,
                                           input logic tr, input logic [1:0] sh);
      return {12'b0, sh, 2'b0, tr, lv, 2'b0, lg, dm, v};
   endfunction

   task automatic wr_reg(input logic [11:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic rd_chk(input string tag, input logic [11:0] a, input logic [31:0] exp);
      bus_addr = a;
      #1;
      chk(tag, bus_rdata, exp);
   endtask

   task automatic handshake(input string tag);
      @(negedge clk);
      msg_ready_i = 1'b1;
      #1 chk({tag, " valid before accept"}, {31'b0, msg_valid_o}, 32'd1);
      @(negedge clk);
      msg_ready_i = 1'b0;
      #1 chk({tag, " valid after accept"}, {31'b0, msg_valid_o}, 32'd0);
   endtask

   task automatic t_reset();
      rd_chk("R1 id", 12'h020, 32'h0);
      rd_chk("R1 spur", 12'h0F0, 32'h0);
      rd_chk("R1 lo", 12'h300, 32'h0);
      rd_chk("R1 hi", 12'h310, 32'h0);
      chk("R1 valid", {31'b0, msg_valid_o}, 32'd0);
      chk("R1 drop", {31'b0, cmd_drop_o}, 32'd0);
      chk("R1 eoi", {31'b0, eoi_o}, 32'd0);
   endtask

   task automatic t_id();
      wr_reg(12'h020, 32'hA5FF_FFFF);
      rd_chk("R2 id", 12'h020, 32'hA500_0000);
      wr_reg(12'h020, 32'h0300_0000);
      rd_chk("R2 id rewrite", 12'h020, 32'h0300_0000);
   endtask

   task automatic t_spur();
      wr_reg(12'h0F0, 32'hFFFF_F0FF);
      rd_chk("R3 spur en=0", 12'h0F0, 32'h0000_00FF);
      wr_reg(12'h0F0, 32'h0000_013C);
      rd_chk("R3 spur en=1", 12'h0F0, 32'h0000_013C);
      wr_reg(12'h0F0, 32'h0000_003C);
      rd_chk("R3 spur disable", 12'h0F0, 32'h0000_003C);
   endtask

   task automatic t_eoi();
      wr_reg(12'h0B0, 32'hDEAD_BEEF);
      chk("R4 eoi pulse", {31'b0, eoi_o}, 32'd1);
      rd_chk("R4 eoi reads zero", 12'h0B0, 32'h0);
      @(negedge clk);
      chk("R4 eoi one cycle", {31'b0, eoi_o}, 32'd0);
   endtask

   task automatic t_hi();
      wr_reg(12'h310, 32'h5AFF_FFFF);
      rd_chk("R5 hi", 12'h310, 32'h5A00_0000);
      chk("R5 no launch", {31'b0, msg_valid_o}, 32'd0);
   endtask

   task automatic t_disabled();
      logic [31:0] w;
      w = lo_word(8'h44, 3'b100, 1'b1, 1'b0, 1'b1, 2'b01);
      wr_reg(12'h300, w);
      chk("R10 no valid", {31'b0, msg_valid_o}, 32'd0);
      rd_chk("R10 stored, idle", 12'h300, w);
      repeat (2) @(negedge clk);
      chk("R10 still idle", {31'b0, msg_valid_o}, 32'd0);
   endtask

   task automatic t_launch_hold_drop();
      logic [31:0] w;
      wr_reg(12'h0F0, 32'h0000_01FF);
      w = lo_word(8'h31, 3'b110, 1'b0, 1'b1, 1'b0, 2'b11);
      wr_reg(12'h300, w);
      chk("R6 valid", {31'b0, msg_valid_o}, 32'd1);
      chk("R6 vector", {24'b0, msg_vector_o}, 32'h31);
      chk("R6 dmode", {29'b0, msg_dmode_o}, 32'd6);
      chk("R6 dlogical", {31'b0, msg_dlogical_o}, 32'd0);
      chk("R6 level", {31'b0, msg_level_o}, 32'd1);
      chk("R6 trig", {31'b0, msg_trig_o}, 32'd0);
      chk("R6 short", {30'b0, msg_short_o}, 32'd3);
      chk("R6 dest", {24'b0, msg_dest_o}, 32'h5A);
      rd_chk("R7 status pending", 12'h300, w | 32'h1000);
      wr_reg(12'h310, 32'hC300_0000);
      rd_chk("R8 hi rewritten", 12'h310, 32'hC300_0000);
      chk("R8 dest held", {24'b0, msg_dest_o}, 32'h5A);
      chk("R8 valid held", {31'b0, msg_valid_o}, 32'd1);
      wr_reg(12'h300, lo_word(8'h77, 3'b001, 1'b1, 1'b0, 1'b1, 2'b00));
      drop_exp = 1;
      chk("R9 drop flag", {31'b0, cmd_drop_o}, 32'd1);
      rd_chk("R9 fields unchanged", 12'h300, w | 32'h3000);
      chk("R8 vector held", {24'b0, msg_vector_o}, 32'h31);
      repeat (3) @(negedge clk);
      chk("R8 valid still held", {31'b0, msg_valid_o}, 32'd1);
      handshake("R7");
      rd_chk("R7 status idle", 12'h300, w | 32'h2000);
      repeat (2) @(negedge clk);
      chk("R9 no second message", {31'b0, msg_valid_o}, 32'd0);
      chk("R9 drop sticky", {31'b0, cmd_drop_o}, 32'd1);
   endtask

   task automatic t_codes();
      for (int sh = 0; sh < 4; sh++) begin
         for (int dm = 0; dm < 8; dm++) begin
            logic [7:0] v;
            v = 8'(16 + sh * 8 + dm);
            wr_reg(12'h310, {8'(dm * 17 + sh), 24'h0});
            wr_reg(12'h300, lo_word(v, 3'(dm), 1'(dm), 1'(sh), 1'(dm >> 1), 2'(sh)));
            chk("R11 dmode", {29'b0, msg_dmode_o}, 32'(dm));
            chk("R11 short", {30'b0, msg_short_o}, 32'(sh));
            chk("R11 vector", {24'b0, msg_vector_o}, {24'b0, v});
            chk("R11 dest", {24'b0, msg_dest_o}, 32'(8'(dm * 17 + sh)));
            chk("R11 dlogical", {31'b0, msg_dlogical_o}, 32'(dm & 1));
            handshake("R11");
         end
      end
   endtask

   initial begin
      #(4 * 200000);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog: actual hung expected finished");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      #1;
      t_reset();
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_id();
      t_spur();
      t_eoi();
      t_hi();
      t_disabled();
      t_launch_hold_drop();
      t_codes();
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule